// File: doc/BRIEF.md
# Memory-Mapped Event Timer with Comparators

A 64-bit free-running tick counter shared by a small set of comparator channels. Software programs it through a word-wide register port. A single write strobe and a single read strobe with a byte address drive the port. Read data comes back one clock after the read strobe. Each channel compares its comparator against the counter and raises a one-clock interrupt pulse on a match. It fires once in one-shot mode. In periodic mode it re-arms itself by adding a stored period.

Periodic channels are loaded with a two-write sequence. The software sets the channel's set-value bit together with periodic mode. The next write to the comparator low word gives the first match point and the write after that gives the reload period. A channel can also compare only the low 32 counter bits, so it wraps every 2^32 ticks. A legacy routing switch takes channels 0 and 1 off the general interrupt vector and puts them on two dedicated lines, a system tick line and a real-time-clock line. A read-only register gives the channel count and whether legacy routing is supported. A second read-only register gives the tick period in femtoseconds, which software checks against a sane window before it uses the block.

Top module: `evt_timer`

Register map (byte addresses, bits [1:0] ignored): 0x000 capabilities, 0x004 period, 0x010 global config, 0x020 match status, 0x0F0/0x0F4 counter low/high, and channel c at 0x100 + 0x20*c with config at +0x0, comparator low at +0x8 and comparator high at +0xC.

## Requirements
- R1: After reset the counter, the global config, every channel config, every comparator and the status register read 0, and all interrupt outputs are low.
- R2: The capabilities word holds the channel count minus one in bits [12:8] and the legacy-support flag in bit 15. The period register returns the femtosecond period parameter. Both ignore writes.
- R3: The counter increments once per clock only while global config bit 0 (run) is set, and it holds its value while run is clear. Its low and high words can each be written on their own.
- R4: A channel with config bit 2 (enable) set and bit 3 (periodic) clear fires exactly once. If the comparator holds N and the counter is at 0 when run is set, the one-clock pulse on its interrupt output is high in the clock after N+1 rising edges. Its comparator does not change.
- R5: A channel whose enable bit is clear raises no interrupt and sets no status bit, even when the counter passes its comparator.
- R6: In periodic mode each match adds the stored period to the comparator on the same clock edge that raises the pulse, so pulses repeat every period ticks and the comparator reads back the advanced value.
- R7: Writing config with bit 6 (set-value) and periodic both set arms the channel, and bit 6 reads 1 while armed. The next comparator-low write sets the match point, the write after that sets the period, and bit 6 then clears itself.
- R8: Channel 1 is built one-shot only: its periodic bit always reads 0 and it never reloads.
- R9: With config bit 8 (32-bit mode) set, a channel compares only counter bits [31:0] against comparator bits [31:0]. With bit 8 clear, all 64 bits must match.
- R10: With global config bit 1 (legacy) set, channel 0 pulses legacy_tick_o, channel 1 pulses legacy_rtc_o, and bits 0 and 1 of irq_o stay low. With it clear, both legacy lines stay low.
- R11: Every channel fire sets status bit c, which stays set until software writes 1 to that bit. Writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; data is valid the following clock |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_CH | Per-channel one-clock match pulses |
| legacy_tick_o | output | 1 | Channel 0 pulse when legacy routing is on |
| legacy_rtc_o | output | 1 | Channel 1 pulse when legacy routing is on |

## Verification
The channel assertions assume at most one register access per clock. They also assume that the only way the comparator changes after a one-shot match is a software write. Both hold at the register port because each directed task issues a single strobe and releases it before the next. Every scenario stops the counter, disables all channels, clears the status bits and writes zero to both counter halves before it programs anything. That way no match left over from an earlier scenario can land inside the window that is being measured.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  // channel config bit positions
  localparam int unsigned CFG_EN_BIT  = 2;
  localparam int unsigned CFG_PER_BIT = 3;
  localparam int unsigned CFG_SET_BIT = 6;
  localparam int unsigned CFG_M32_BIT = 8;
  // global config bit positions
  localparam int unsigned GCFG_RUN_BIT = 0;
  localparam int unsigned GCFG_LEG_BIT = 1;
  // capabilities fields
  localparam int unsigned CAP_NUM_LSB = 8;
  localparam int unsigned CAP_NUM_W   = 5;
  localparam int unsigned CAP_LEG_BIT = 15;
  // address map
  localparam logic [11:0] A_CAPS   = 12'h000;
  localparam logic [11:0] A_PERIOD = 12'h004;
  localparam logic [11:0] A_GCFG   = 12'h010;
  localparam logic [11:0] A_STAT   = 12'h020;
  localparam logic [11:0] A_CNT_LO = 12'h0F0;
  localparam logic [11:0] A_CNT_HI = 12'h0F4;
  localparam logic [3:0]  CH_REGION  = 4'h1;
  localparam logic [2:0]  OFF_CFG    = 3'd0;
  localparam logic [2:0]  OFF_CMP_LO = 3'd2;
  localparam logic [2:0]  OFF_CMP_HI = 3'd3;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WAIT_CMP, SEQ_WAIT_PER} seq_e;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int unsigned W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           wr_lo_i,
  input  logic           wr_hi_i,
  input  logic [W/2-1:0] wdata_i,
  output logic [W-1:0]   cnt_o
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (run_i)   cnt_d = cnt_q + W'(1);
    if (wr_lo_i) cnt_d[HALF-1:0] = wdata_i;
    if (wr_hi_i) cnt_d[W-1:HALF] = wdata_i;
  end

  assign cnt_en = run_i | wr_lo_i | wr_hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter int unsigned W = 64,
  parameter bit PERIODIC_OK = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic [W-1:0]   cnt_i,
  input  logic           cfg_we_i,
  input  logic           cmp_lo_we_i,
  input  logic           cmp_hi_we_i,
  input  logic [W/2-1:0] wdata_i,
  output logic [31:0]    cfg_o,
  output logic [W-1:0]   cmp_o,
  output logic           fire_o
);
  localparam int unsigned HALF = W / 2;

  logic         en_q, en_d, per_q, per_d, m32_q, m32_d;
  seq_e         seq_q, seq_d;
  logic [W-1:0] cmp_q, cmp_d, prd_q, prd_d, reload;
  logic         fire_q, hit, lo_eq, hi_eq;

  assign lo_eq = (cnt_i[HALF-1:0] == cmp_q[HALF-1:0]);
  assign hi_eq = (cnt_i[W-1:HALF] == cmp_q[W-1:HALF]);
  assign hit   = en_q & run_i & lo_eq & (m32_q | hi_eq);

  always_comb begin
    if (m32_q) reload = {cmp_q[W-1:HALF], cmp_q[HALF-1:0] + prd_q[HALF-1:0]};
    else       reload = cmp_q + prd_q;
  end

  always_comb begin
    en_d  = en_q;
    per_d = per_q;
    m32_d = m32_q;
    seq_d = seq_q;
    cmp_d = cmp_q;
    prd_d = prd_q;
    if (cfg_we_i) begin
      en_d  = wdata_i[CFG_EN_BIT];
      per_d = wdata_i[CFG_PER_BIT] & PERIODIC_OK;
      m32_d = wdata_i[CFG_M32_BIT];
      seq_d = (wdata_i[CFG_SET_BIT] && per_d) ? SEQ_WAIT_CMP : SEQ_IDLE;
    end
    if (hit && per_q) cmp_d = reload;
    if (cmp_lo_we_i) begin
      if (seq_q == SEQ_WAIT_PER) begin
        prd_d[HALF-1:0] = wdata_i;
        seq_d = SEQ_IDLE;
      end else begin
        cmp_d[HALF-1:0] = wdata_i;
        if (seq_q == SEQ_WAIT_CMP) seq_d = SEQ_WAIT_PER;
      end
    end
    if (cmp_hi_we_i) begin
      if (seq_q == SEQ_WAIT_PER) prd_d[W-1:HALF] = wdata_i;
      else                       cmp_d[W-1:HALF] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      m32_q  <= 1'b0;
      seq_q  <= SEQ_IDLE;
      cmp_q  <= '0;
      prd_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      per_q  <= per_d;
      m32_q  <= m32_d;
      seq_q  <= seq_d;
      cmp_q  <= cmp_d;
      prd_q  <= prd_d;
      fire_q <= hit;
    end
  end

  always_comb begin
    cfg_o = '0;
    cfg_o[CFG_EN_BIT]  = en_q;
    cfg_o[CFG_PER_BIT] = per_q;
    cfg_o[CFG_SET_BIT] = (seq_q != SEQ_IDLE);
    cfg_o[CFG_M32_BIT] = m32_q;
  end

  assign cmp_o  = cmp_q;
  assign fire_o = fire_q;

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !fire_o);

  assert_setval_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SEQ_WAIT_PER && cmp_lo_we_i && !cfg_we_i) |=> !cfg_o[CFG_SET_BIT]);

  assert_oneshot_keeps_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !per_q && !cmp_lo_we_i && !cmp_hi_we_i) |=> $stable(cmp_o));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned NUM_CH      = 3,
  parameter logic [31:0] PERIOD_FS   = 32'd69841279,
  parameter logic [NUM_CH-1:0] PERIODIC_CH = ~(NUM_CH'(2)),
  parameter bit          LEGACY_CAP  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic [NUM_CH-1:0] irq_o,
  output logic              legacy_tick_o,
  output logic              legacy_rtc_o
);
  localparam int unsigned CW   = 64;
  localparam int unsigned HALF = CW / 2;

  logic              rst_sync_n;
  logic [11:0]       word_addr;
  logic [2:0]        ch_off;
  logic [1:0]        gcfg_q, gcfg_d;
  logic [NUM_CH-1:0] stat_q, stat_d, ch_fire, ch_sel, legacy_mask;
  logic [31:0]       rdata_q, rdata_d, caps;
  logic [CW-1:0]     cnt;
  logic [31:0]       ch_cfg [NUM_CH];
  logic [CW-1:0]     ch_cmp [NUM_CH];
  logic              wr_gcfg, wr_stat, wr_cnt_lo, wr_cnt_hi;

  evt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign word_addr = {reg_addr[11:2], 2'b00};
  assign ch_off    = word_addr[4:2];
  assign wr_gcfg   = reg_wr && (word_addr == A_GCFG);
  assign wr_stat   = reg_wr && (word_addr == A_STAT);
  assign wr_cnt_lo = reg_wr && (word_addr == A_CNT_LO);
  assign wr_cnt_hi = reg_wr && (word_addr == A_CNT_HI);

  evt_main_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run_i(gcfg_q[GCFG_RUN_BIT]),
    .wr_lo_i(wr_cnt_lo), .wr_hi_i(wr_cnt_hi), .wdata_i(reg_wdata), .cnt_o(cnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_sel[i] = (word_addr[11:8] == CH_REGION) && (word_addr[7:5] == 3'(i));
    evt_channel #(.W(CW), .PERIODIC_OK(PERIODIC_CH[i])) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .run_i(gcfg_q[GCFG_RUN_BIT]), .cnt_i(cnt),
      .cfg_we_i(reg_wr && ch_sel[i] && ch_off == OFF_CFG),
      .cmp_lo_we_i(reg_wr && ch_sel[i] && ch_off == OFF_CMP_LO),
      .cmp_hi_we_i(reg_wr && ch_sel[i] && ch_off == OFF_CMP_HI),
      .wdata_i(reg_wdata), .cfg_o(ch_cfg[i]), .cmp_o(ch_cmp[i]), .fire_o(ch_fire[i])
    );

    assert_fire_sets_status_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ch_fire[i] |=> stat_q[i]);
    assert_status_sticky_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (stat_q[i] && !(wr_stat && reg_wdata[i])) |=> stat_q[i]);
  end

  // global config and sticky status
  always_comb begin
    gcfg_d = gcfg_q;
    if (wr_gcfg) begin
      gcfg_d[GCFG_RUN_BIT] = reg_wdata[GCFG_RUN_BIT];
      gcfg_d[GCFG_LEG_BIT] = reg_wdata[GCFG_LEG_BIT] & LEGACY_CAP;
    end
    stat_d = stat_q;
    if (wr_stat) stat_d = stat_d & ~reg_wdata[NUM_CH-1:0];
    stat_d = stat_d | ch_fire;
  end

  always_comb begin
    caps = '0;
    caps[CAP_NUM_LSB +: CAP_NUM_W] = CAP_NUM_W'(NUM_CH - 1);
    caps[CAP_LEG_BIT] = LEGACY_CAP;
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    case (word_addr)
      A_CAPS:   rdata_d = caps;
      A_PERIOD: rdata_d = PERIOD_FS;
      A_GCFG:   rdata_d = {30'd0, gcfg_q};
      A_STAT:   rdata_d[NUM_CH-1:0] = stat_q;
      A_CNT_LO: rdata_d = cnt[HALF-1:0];
      A_CNT_HI: rdata_d = cnt[CW-1:HALF];
      default:  rdata_d = '0;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel[c]) begin
        case (ch_off)
          OFF_CFG:    rdata_d = ch_cfg[c];
          OFF_CMP_LO: rdata_d = ch_cmp[c][HALF-1:0];
          OFF_CMP_HI: rdata_d = ch_cmp[c][CW-1:HALF];
          default:    rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gcfg_q <= '0;
      stat_q <= '0;
    end else begin
      gcfg_q <= gcfg_d;
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (reg_rd)  rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  // legacy routing of channels 0 and 1
  always_comb begin
    legacy_mask = '0;
    legacy_mask[0] = gcfg_q[GCFG_LEG_BIT];
    legacy_mask[1] = gcfg_q[GCFG_LEG_BIT];
  end

  assign irq_o         = ch_fire & ~legacy_mask;
  assign legacy_tick_o = gcfg_q[GCFG_LEG_BIT] & ch_fire[0];
  assign legacy_rtc_o  = gcfg_q[GCFG_LEG_BIT] & ch_fire[1];

  assert_legacy_split_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ch_fire[1] && gcfg_q[GCFG_LEG_BIT]) |-> (legacy_rtc_o && !irq_o[1]));
endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  localparam int NCH = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic            reg_rd = 1'b0;
  logic [31:0]     reg_rdata;
  logic [NCH-1:0]  irq_o;
  logic            legacy_tick_o, legacy_rtc_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  evt_timer #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .legacy_tick_o(legacy_tick_o), .legacy_rtc_o(legacy_rtc_o)
  );

  function automatic logic [11:0] ch_addr(input int c, input int off);
    return 12'h100 + 12'(c * 32) + 12'(off);
  endfunction

  function automatic logic [4:0] lines();
    return {legacy_rtc_o, legacy_tick_o, irq_o};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic prep();
    wr(12'h010, 32'h0);
    for (int c = 0; c < NCH; c++) wr(ch_addr(c, 0), 32'h0);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h0F0, 32'h0);
    wr(12'h0F4, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq lines", 64'(lines()), 64'h0);
    rd(12'h0F0, d); check("R1 counter lo", 64'(d), 64'h0);
    rd(12'h010, d); check("R1 gcfg", 64'(d), 64'h0);
    rd(ch_addr(0, 0), d); check("R1 ch0 cfg", 64'(d), 64'h0);
    rd(ch_addr(2, 8), d); check("R1 ch2 cmp", 64'(d), 64'h0);
    rd(12'h020, d); check("R1 status", 64'(d), 64'h0);
  endtask

  task automatic t_caps();
    logic [31:0] d;
    rd(12'h000, d); check("R2 caps", 64'(d), 64'h8200);
    wr(12'h004, 32'h1234);
    rd(12'h004, d); check("R2 period", 64'(d), 64'd69841279);
  endtask

  task automatic t_counter();
    logic [31:0] d;
    prep();
    wr(12'h0F0, 32'h100);
    wr(12'h0F4, 32'h7);
    repeat (10) @(negedge clk);
    rd(12'h0F0, d); check("R3 stopped lo", 64'(d), 64'h100);
    rd(12'h0F4, d); check("R3 hi write", 64'(d), 64'h7);
    wr(12'h010, 32'h1);
    repeat (9) @(negedge clk);
    wr(12'h010, 32'h0);
    rd(12'h0F0, d); check("R3 running lo", 64'(d), 64'h10A);
  endtask

  task automatic t_oneshot();
    int first = 0, cnt = 0;
    logic [31:0] d;
    prep();
    wr(ch_addr(0, 8), 32'd12);
    wr(ch_addr(0, 0), 32'h4);
    wr(12'h010, 32'h1);
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (irq_o[0]) begin cnt++; if (first == 0) first = n; end
    end
    check("R4 first pulse edge", 64'(first), 64'd13);
    check("R4 pulse count", 64'(cnt), 64'd1);
    wr(12'h010, 32'h0);
    rd(ch_addr(0, 8), d); check("R4 cmp unchanged", 64'(d), 64'd12);
  endtask

  task automatic t_status();
    logic [31:0] d;
    rd(12'h020, d); check("R11 status set", 64'(d[0]), 64'h1);
    wr(12'h020, 32'h0);
    rd(12'h020, d); check("R11 write 0 keeps", 64'(d[0]), 64'h1);
    wr(12'h020, 32'h1);
    rd(12'h020, d); check("R11 write 1 clears", 64'(d[0]), 64'h0);
  endtask

  task automatic t_disabled();
    int cnt = 0;
    logic [31:0] d;
    prep();
    wr(ch_addr(2, 8), 32'd12);
    wr(ch_addr(2, 0), 32'h0);
    wr(12'h010, 32'h1);
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (irq_o[2]) cnt++;
    end
    wr(12'h010, 32'h0);
    check("R5 no pulse", 64'(cnt), 64'd0);
    rd(12'h020, d); check("R5 no status", 64'(d[2]), 64'h0);
  endtask

  task automatic t_periodic();
    int hits[3];
    int k = 0;
    logic [31:0] d;
    prep();
    wr(ch_addr(0, 0), 32'h4C);
    rd(ch_addr(0, 0), d); check("R7 armed bit", 64'(d[6]), 64'h1);
    wr(ch_addr(0, 8), 32'd20);
    wr(ch_addr(0, 8), 32'd8);
    rd(ch_addr(0, 0), d); check("R7 self clear", 64'(d), 64'h0C);
    rd(ch_addr(0, 8), d); check("R7 first write is cmp", 64'(d), 64'd20);
    wr(12'h010, 32'h1);
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (irq_o[0]) begin
        if (k < 3) hits[k] = n;
        k++;
      end
    end
    wr(12'h010, 32'h0);
    check("R6 pulse count", 64'(k), 64'd3);
    check("R6 pulse 1", 64'(hits[0]), 64'd21);
    check("R6 pulse 2", 64'(hits[1]), 64'd29);
    check("R6 pulse 3", 64'(hits[2]), 64'd37);
    rd(ch_addr(0, 8), d); check("R6 cmp advanced", 64'(d), 64'd44);
  endtask

  task automatic t_oneshot_only();
    logic [31:0] d;
    prep();
    wr(ch_addr(1, 0), 32'h4C);
    rd(ch_addr(1, 0), d);
    check("R8 periodic bit", 64'(d[3]), 64'h0);
    check("R8 enable kept", 64'(d[2]), 64'h1);
    check("R8 not armed", 64'(d[6]), 64'h0);
  endtask

  task automatic t_mode32();
    int first = 0, cnt = 0;
    prep();
    wr(12'h0F4, 32'd5);
    wr(ch_addr(1, 8), 32'd10);
    wr(ch_addr(1, 0), 32'h4);
    wr(12'h010, 32'h1);
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (irq_o[1]) cnt++;
    end
    wr(12'h010, 32'h0);
    check("R9 64-bit no match", 64'(cnt), 64'd0);
    wr(12'h0F0, 32'h0);
    wr(ch_addr(1, 0), 32'h104);
    wr(12'h010, 32'h1);
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (irq_o[1] && first == 0) first = n;
    end
    wr(12'h010, 32'h0);
    check("R9 32-bit match edge", 64'(first), 64'd11);
  endtask

  task automatic t_legacy();
    int tick = 0, rtc = 0, stray = 0;
    logic [31:0] d;
    prep();
    wr(ch_addr(0, 8), 32'd10);
    wr(ch_addr(0, 0), 32'h4);
    wr(ch_addr(1, 8), 32'd15);
    wr(ch_addr(1, 0), 32'h4);
    wr(12'h010, 32'h3);
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (legacy_tick_o && tick == 0) tick = n;
      if (legacy_rtc_o && rtc == 0) rtc = n;
      if (irq_o[1:0] != 2'b00) stray++;
    end
    rd(12'h010, d); check("R10 gcfg", 64'(d), 64'h3);
    wr(12'h010, 32'h0);
    check("R10 tick line", 64'(tick), 64'd11);
    check("R10 rtc line", 64'(rtc), 64'd16);
    check("R10 general lines quiet", 64'(stray), 64'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_caps();
    t_counter();
    t_oneshot();
    t_status();
    t_disabled();
    t_periodic();
    t_oneshot_only();
    t_mode32();
    t_legacy();
    finish_run();
  end
endmodule